// File: doc/BRIEF.md
# Adjustable Interlaced Sync Timing Generator

The block produces the full set of raster timing signals for standard-definition video: an active-low horizontal sync, an active-low vertical sync, a data-enable window, a field indicator pin, and the flags and position strobes that a downstream encoder uses to build start/end-of-active-video code words (a vertical blanking flag, a field flag, and one-cycle strobes at the start-of-active and end-of-active points). A pixel counter and a line counter run freely. Every edge is found by comparing those counters against a nominal position plus a programmable signed offset.

Horizontal edges each take a 12-bit offset. Vertical edges take 6-bit offsets, with one offset for the odd field and another for the even field. The horizontal point at which vertical sync and the field pin change is selectable. One choice keeps it near the leading edge of horizontal sync, and the other moves it about half a line further on. Each of these two choices has its own horizontal offset. All vertical events happen a fixed number of lines (default four) after their nominal lines. Software writes offsets through a simple byte-wide write port. A written value becomes effective only at the next frame start.

Top module: `sg_timing_gen`

## Requirements
- R1: The pixel counter runs 0..H_TOTAL-1 and the line counter advances by one at the end of each line, wrapping after V_TOTAL lines. Consecutive start-of-active strobes are H_TOTAL cycles apart, and a frame holds V_TOTAL of them.
- R2: With zero offsets, hs_n_o is low for HS_WID_NOM pixels starting at pixel HS_BEG_NOM. sav_o is a one-cycle strobe at pixel H_TOTAL-4 and eav_o is a one-cycle strobe at pixel H_ACTIVE.
- R3: de_o is high only where the pixel lies in [DE begin, DE end) (default 0..H_ACTIVE-1) and v_bit_o is low.
- R4: v_bit_o rises at the end-of-active pixel of the blanking-begin line for each field and falls at the end-of-active pixel of that field's blanking-end line.
- R5: Every vertical event occurs V_DELAY lines after its nominal line, with the default offsets.
- R6: vs_n_o goes low on each field's sync-begin line and returns high on its sync-end line. Both changes happen at the vertical change point.
- R7: field_o goes to 1 on the even-field toggle line and to 0 on the odd-field toggle line, at the vertical change point. f_bit_o does the same at the end-of-active pixel on its own lines.
- R8: A horizontal offset is a two's-complement value added to the nominal position, and the sum wraps modulo H_TOTAL.
- R9: Vertical offsets are signed 6-bit values held per field. A change to one field leaves the other field's edge in place, and the sum wraps modulo V_TOTAL.
- R10: Horizontal offset i is written as the upper 4 bits at address 2i and the lower 8 bits at address 2i+1, with index order SAV, EAV, HS begin, HS width, DE begin, DE end, change-point begin, change-point mid. The value is staged only when both halves have been written.
- R11: Staged offsets and the mode bit become active only at the start of a frame. A write leaves the current frame unchanged.
- R12: Mode bit 0 at address 28 selects the vertical change point. With 0 the point is HS_BEG_NOM plus the begin offset. With 1 it is HS_BEG_NOM+H_TOTAL/2 plus the mid offset, taken modulo H_TOTAL. Vertical offset k lives at address 16+k, with k order: V-begin odd/even, V-end odd/even, F odd/even, field odd/even, VS-begin odd/even, VS-end odd/even.
- R13: In reset, hs_n_o=1, vs_n_o=1, de_o=0, v_bit_o=1, f_bit_o=0, field_o=0, sav_o=0, eav_o=0, and all offsets and the mode are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | ADDR_W | Register write address |
| wr_data_i | input | 8 | Register write data |
| hs_n_o | output | 1 | Horizontal sync, active low |
| vs_n_o | output | 1 | Vertical sync, active low |
| de_o | output | 1 | Active video window |
| field_o | output | 1 | Field pin, 1 = even field |
| v_bit_o | output | 1 | Vertical blanking flag for code words |
| f_bit_o | output | 1 | Field flag for code words |
| sav_o | output | 1 | Start-of-active code position strobe |
| eav_o | output | 1 | End-of-active code position strobe |

## Verification
A corrupted pixel counter or a wrongly computed horizontal position moves sync, data-enable or a strobe within the same line. Within one line period it shows up as a wrong pulse width or a wrong strobe spacing. Faults in line counting, in the per-field event lines or in the vertical delay show at the ports only on the affected line. They therefore need up to one frame to appear, and the tests sample on the lines either side of each event. Faults in the offset staging or frame commit show one frame late or one frame early, so each offset test compares the frame in which the write happens with the frame that follows it.

// File: rtl/sg_pkg.sv
package sg_pkg;
  localparam int HADJ_W    = 12;
  localparam int VADJ_W    = 6;
  localparam int N_HREG    = 8;
  localparam int N_VREG    = 12;
  localparam int VREG_BASE = 16;
  localparam int MODE_ADDR = 28;

  // horizontal offset index
  localparam int HI_SAV     = 0;
  localparam int HI_EAV     = 1;
  localparam int HI_HS_BEG  = 2;
  localparam int HI_HS_WID  = 3;
  localparam int HI_DE_BEG  = 4;
  localparam int HI_DE_END  = 5;
  localparam int HI_VSF_BEG = 6;
  localparam int HI_VSF_MID = 7;

  // vertical offset index (odd, even pairs)
  localparam int VI_VB_BEG_O = 0;
  localparam int VI_VB_BEG_E = 1;
  localparam int VI_VB_END_O = 2;
  localparam int VI_VB_END_E = 3;
  localparam int VI_FB_O     = 4;
  localparam int VI_FB_E     = 5;
  localparam int VI_FLD_O    = 6;
  localparam int VI_FLD_E    = 7;
  localparam int VI_VS_BEG_O = 8;
  localparam int VI_VS_BEG_E = 9;
  localparam int VI_VS_END_O = 10;
  localparam int VI_VS_END_E = 11;

  // nominal + signed offset, folded into [0, total)
  function automatic int wrap_mod(int nom, int adj, int total);
    int s;
    s = (nom + adj) % total;
    if (s < 0) s = s + total;
    return s;
  endfunction

  // distance from beg forward to pos, in [0, total)
  function automatic int fwd_dist(int pos, int beg, int total);
    int d;
    d = pos - beg;
    if (d < 0) d = d + total;
    return d;
  endfunction
endpackage

// File: rtl/sg_regs.sv
module sg_regs
  import sg_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          wr_en_i,
  input  logic [ADDR_W-1:0]             wr_addr_i,
  input  logic [7:0]                    wr_data_i,
  input  logic                          commit_i,
  output logic [N_HREG-1:0][HADJ_W-1:0] h_adj_o,
  output logic [N_VREG-1:0][VADJ_W-1:0] v_adj_o,
  output logic                          mid_mode_o
);
  localparam int HI_W = HADJ_W - 8;

  for (genvar i = 0; i < N_HREG; i++) begin : g_h
    logic              hi_wr, lo_wr;
    logic [HI_W-1:0]   hi_q;
    logic [7:0]        lo_q;
    logic              hi_seen_q, lo_seen_q;
    logic [HADJ_W-1:0] stage_q, act_q;

    assign hi_wr = wr_en_i && (wr_addr_i == ADDR_W'(2 * i));
    assign lo_wr = wr_en_i && (wr_addr_i == ADDR_W'(2 * i + 1));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        hi_q      <= '0;
        lo_q      <= '0;
        hi_seen_q <= 1'b0;
        lo_seen_q <= 1'b0;
        stage_q   <= '0;
        act_q     <= '0;
      end else begin
        if (hi_wr) hi_q <= wr_data_i[HI_W-1:0];
        if (lo_wr) lo_q <= wr_data_i;
        if ((hi_wr || hi_seen_q) && (lo_wr || lo_seen_q)) begin
          stage_q   <= {(hi_wr ? wr_data_i[HI_W-1:0] : hi_q), (lo_wr ? wr_data_i : lo_q)};
          hi_seen_q <= 1'b0;
          lo_seen_q <= 1'b0;
        end else begin
          if (hi_wr) hi_seen_q <= 1'b1;
          if (lo_wr) lo_seen_q <= 1'b1;
        end
        if (commit_i) act_q <= stage_q;
      end
    end
    assign h_adj_o[i] = act_q;
  end

  for (genvar k = 0; k < N_VREG; k++) begin : g_v
    logic              wr;
    logic [VADJ_W-1:0] stage_q, act_q;

    assign wr = wr_en_i && (wr_addr_i == ADDR_W'(VREG_BASE + k));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        stage_q <= '0;
        act_q   <= '0;
      end else begin
        if (wr)       stage_q <= wr_data_i[VADJ_W-1:0];
        if (commit_i) act_q   <= stage_q;
      end
    end
    assign v_adj_o[k] = act_q;
  end

  logic mode_stage_q, mode_act_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_stage_q <= 1'b0;
      mode_act_q   <= 1'b0;
    end else begin
      if (wr_en_i && (wr_addr_i == ADDR_W'(MODE_ADDR))) mode_stage_q <= wr_data_i[0];
      if (commit_i) mode_act_q <= mode_stage_q;
    end
  end
  assign mid_mode_o = mode_act_q;
endmodule

// File: rtl/sg_hgen.sv
module sg_hgen
  import sg_pkg::*;
#(
  parameter int H_TOTAL    = 858,
  parameter int H_ACTIVE   = 720,
  parameter int HS_BEG_NOM = 736,
  parameter int HS_WID_NOM = 62,
  localparam int H_W       = $clog2(H_TOTAL)
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [N_HREG-1:0][HADJ_W-1:0] h_adj_i,
  input  logic                          mid_mode_i,
  output logic [H_W-1:0]                hcnt_o,
  output logic                          line_end_o,
  output logic                          eav_pt_o,
  output logic                          vsf_pt_o,
  output logic                          hs_n_o,
  output logic                          h_act_o,
  output logic                          sav_o,
  output logic                          eav_o
);
  localparam int H_NOM [N_HREG] = '{
    H_TOTAL - 4, H_ACTIVE, HS_BEG_NOM, HS_WID_NOM,
    0, H_ACTIVE, HS_BEG_NOM, HS_BEG_NOM + H_TOTAL / 2};

  logic [H_W-1:0] hcnt_q;
  logic [H_W-1:0] pos [N_HREG];

  for (genvar i = 0; i < N_HREG; i++) begin : g_pos
    assign pos[i] = H_W'(wrap_mod(H_NOM[i], int'($signed(h_adj_i[i])), H_TOTAL));
  end

  assign line_end_o = (hcnt_q == H_W'(H_TOTAL - 1));
  assign hcnt_o     = hcnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         hcnt_q <= '0;
    else if (line_end_o) hcnt_q <= '0;
    else                 hcnt_q <= hcnt_q + 1'b1;
  end

  logic hs_act, de_win, sav_hit, eav_hit, vsf_hit;

  always_comb begin
    int hs_rel, de_rel, de_len;
    hs_rel  = fwd_dist(int'(hcnt_q), int'(pos[HI_HS_BEG]), H_TOTAL);
    de_rel  = fwd_dist(int'(hcnt_q), int'(pos[HI_DE_BEG]), H_TOTAL);
    de_len  = fwd_dist(int'(pos[HI_DE_END]), int'(pos[HI_DE_BEG]), H_TOTAL);
    hs_act  = hs_rel < int'(pos[HI_HS_WID]);
    de_win  = de_rel < de_len;
    sav_hit = (hcnt_q == pos[HI_SAV]);
    eav_hit = (hcnt_q == pos[HI_EAV]);
    vsf_hit = mid_mode_i ? (hcnt_q == pos[HI_VSF_MID]) : (hcnt_q == pos[HI_VSF_BEG]);
  end

  assign eav_pt_o = eav_hit;
  assign vsf_pt_o = vsf_hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hs_n_o  <= 1'b1;
      h_act_o <= 1'b0;
      sav_o   <= 1'b0;
      eav_o   <= 1'b0;
    end else begin
      hs_n_o  <= ~hs_act;
      h_act_o <= de_win;
      sav_o   <= sav_hit;
      eav_o   <= eav_hit;
    end
  end
endmodule

// File: rtl/sg_vgen.sv
module sg_vgen
  import sg_pkg::*;
#(
  parameter int V_TOTAL   = 525,
  parameter int V_DELAY   = 4,
  parameter int VB_BEG_O  = 0,
  parameter int VB_END_O  = 19,
  parameter int VB_BEG_E  = 262,
  parameter int VB_END_E  = 282,
  parameter int FTOG_O    = 0,
  parameter int FTOG_E    = 262,
  parameter int VS_BEG_O  = 3,
  parameter int VS_END_O  = 6,
  parameter int VS_BEG_E  = 265,
  parameter int VS_END_E  = 268,
  localparam int V_W      = $clog2(V_TOTAL)
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          line_end_i,
  input  logic                          eav_pt_i,
  input  logic                          vsf_pt_i,
  input  logic [N_VREG-1:0][VADJ_W-1:0] v_adj_i,
  output logic [V_W-1:0]                vcnt_o,
  output logic                          frame_end_o,
  output logic                          v_bit_o,
  output logic                          f_bit_o,
  output logic                          field_o,
  output logic                          vs_n_o
);
  // field pin and F flag share nominal toggle lines
  localparam int V_NOM [N_VREG] = '{
    VB_BEG_O, VB_BEG_E, VB_END_O, VB_END_E,
    FTOG_O, FTOG_E, FTOG_O, FTOG_E,
    VS_BEG_O, VS_BEG_E, VS_END_O, VS_END_E};

  logic [V_W-1:0] vcnt_q;
  logic [N_VREG-1:0] on_line;

  for (genvar k = 0; k < N_VREG; k++) begin : g_ev
    logic [V_W-1:0] ev_line;
    assign ev_line    = V_W'(wrap_mod(V_NOM[k] + V_DELAY, int'($signed(v_adj_i[k])), V_TOTAL));
    assign on_line[k] = (vcnt_q == ev_line);
  end

  assign frame_end_o = line_end_i && (vcnt_q == V_W'(V_TOTAL - 1));
  assign vcnt_o      = vcnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          vcnt_q <= '0;
    else if (frame_end_o) vcnt_q <= '0;
    else if (line_end_i)  vcnt_q <= vcnt_q + 1'b1;
  end

  logic vb_set, vb_clr, fb_odd, fb_even, fld_odd, fld_even, vs_set, vs_clr;
  assign vb_set   = eav_pt_i && (on_line[VI_VB_BEG_O] || on_line[VI_VB_BEG_E]);
  assign vb_clr   = eav_pt_i && (on_line[VI_VB_END_O] || on_line[VI_VB_END_E]);
  assign fb_odd   = eav_pt_i && on_line[VI_FB_O];
  assign fb_even  = eav_pt_i && on_line[VI_FB_E];
  assign fld_odd  = vsf_pt_i && on_line[VI_FLD_O];
  assign fld_even = vsf_pt_i && on_line[VI_FLD_E];
  assign vs_set   = vsf_pt_i && (on_line[VI_VS_BEG_O] || on_line[VI_VS_BEG_E]);
  assign vs_clr   = vsf_pt_i && (on_line[VI_VS_END_O] || on_line[VI_VS_END_E]);

  logic vs_act_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v_bit_o  <= 1'b1;
      f_bit_o  <= 1'b0;
      field_o  <= 1'b0;
      vs_act_q <= 1'b0;
    end else begin
      // begin/even events win a same-pixel collision
      if (vb_set)        v_bit_o  <= 1'b1;
      else if (vb_clr)   v_bit_o  <= 1'b0;
      if (fb_even)       f_bit_o  <= 1'b1;
      else if (fb_odd)   f_bit_o  <= 1'b0;
      if (fld_even)      field_o  <= 1'b1;
      else if (fld_odd)  field_o  <= 1'b0;
      if (vs_set)        vs_act_q <= 1'b1;
      else if (vs_clr)   vs_act_q <= 1'b0;
    end
  end
  assign vs_n_o = ~vs_act_q;
endmodule

// File: rtl/sg_timing_gen.sv
module sg_timing_gen
  import sg_pkg::*;
#(
  parameter int ADDR_W     = 5,
  parameter int H_TOTAL    = 858,
  parameter int H_ACTIVE   = 720,
  parameter int HS_BEG_NOM = 736,
  parameter int HS_WID_NOM = 62,
  parameter int V_TOTAL    = 525,
  parameter int V_DELAY    = 4,
  parameter int VB_BEG_O   = 0,
  parameter int VB_END_O   = 19,
  parameter int VB_BEG_E   = 262,
  parameter int VB_END_E   = 282,
  parameter int FTOG_O     = 0,
  parameter int FTOG_E     = 262,
  parameter int VS_BEG_O   = 3,
  parameter int VS_END_O   = 6,
  parameter int VS_BEG_E   = 265,
  parameter int VS_END_E   = 268,
  localparam int H_W       = $clog2(H_TOTAL),
  localparam int V_W       = $clog2(V_TOTAL)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [7:0]        wr_data_i,
  output logic              hs_n_o,
  output logic              vs_n_o,
  output logic              de_o,
  output logic              field_o,
  output logic              v_bit_o,
  output logic              f_bit_o,
  output logic              sav_o,
  output logic              eav_o
);
  logic [N_HREG-1:0][HADJ_W-1:0] h_adj;
  logic [N_VREG-1:0][VADJ_W-1:0] v_adj;
  logic                          mid_mode;
  logic [H_W-1:0]                hcnt;
  logic [V_W-1:0]                vcnt;
  logic                          line_end, frame_end, eav_pt, vsf_pt, h_act;

  sg_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .wr_addr_i  (wr_addr_i),
    .wr_data_i  (wr_data_i),
    .commit_i   (frame_end),
    .h_adj_o    (h_adj),
    .v_adj_o    (v_adj),
    .mid_mode_o (mid_mode)
  );

  sg_hgen #(
    .H_TOTAL    (H_TOTAL),
    .H_ACTIVE   (H_ACTIVE),
    .HS_BEG_NOM (HS_BEG_NOM),
    .HS_WID_NOM (HS_WID_NOM)
  ) u_hgen (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .h_adj_i    (h_adj),
    .mid_mode_i (mid_mode),
    .hcnt_o     (hcnt),
    .line_end_o (line_end),
    .eav_pt_o   (eav_pt),
    .vsf_pt_o   (vsf_pt),
    .hs_n_o     (hs_n_o),
    .h_act_o    (h_act),
    .sav_o      (sav_o),
    .eav_o      (eav_o)
  );

  sg_vgen #(
    .V_TOTAL  (V_TOTAL),
    .V_DELAY  (V_DELAY),
    .VB_BEG_O (VB_BEG_O),
    .VB_END_O (VB_END_O),
    .VB_BEG_E (VB_BEG_E),
    .VB_END_E (VB_END_E),
    .FTOG_O   (FTOG_O),
    .FTOG_E   (FTOG_E),
    .VS_BEG_O (VS_BEG_O),
    .VS_END_O (VS_END_O),
    .VS_BEG_E (VS_BEG_E),
    .VS_END_E (VS_END_E)
  ) u_vgen (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .line_end_i  (line_end),
    .eav_pt_i    (eav_pt),
    .vsf_pt_i    (vsf_pt),
    .v_adj_i     (v_adj),
    .vcnt_o      (vcnt),
    .frame_end_o (frame_end),
    .v_bit_o     (v_bit_o),
    .f_bit_o     (f_bit_o),
    .field_o     (field_o),
    .vs_n_o      (vs_n_o)
  );

  assign de_o = h_act & ~v_bit_o;
endmodule

// File: rtl/sg_timing_gen_chk.sv
module sg_timing_gen_chk
  import sg_pkg::*;
#(
  parameter int H_TOTAL = 858,
  parameter int V_TOTAL = 525,
  localparam int H_W    = $clog2(H_TOTAL),
  localparam int V_W    = $clog2(V_TOTAL)
) (
  input logic                          clk_i,
  input logic                          rst_ni,
  input logic [H_W-1:0]                hcnt_i,
  input logic [V_W-1:0]                vcnt_i,
  input logic                          commit_i,
  input logic [N_HREG-1:0][HADJ_W-1:0] h_adj_i,
  input logic [N_VREG-1:0][VADJ_W-1:0] v_adj_i,
  input logic                          mid_mode_i,
  input logic                          eav_pt_i,
  input logic                          vsf_pt_i,
  input logic                          de_i,
  input logic                          v_bit_i,
  input logic                          field_i,
  input logic                          vs_n_i,
  input logic                          eav_i
);
  // R1
  h_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(hcnt_i) < H_TOTAL) && (int'(vcnt_i) < V_TOTAL));

  // R1
  line_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hcnt_i == H_W'(H_TOTAL - 1)) |=> (hcnt_i == '0) &&
      (vcnt_i == (($past(vcnt_i) == V_W'(V_TOTAL - 1)) ? '0 : $past(vcnt_i) + 1'b1)));

  // R2
  eav_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eav_i |=> !eav_i);

  // R3
  de_vert_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    de_i |-> !v_bit_i);

  // R4
  vbit_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (v_bit_i != $past(v_bit_i)) |-> $past(eav_pt_i));

  // R6
  vs_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vs_n_i != $past(vs_n_i)) |-> $past(vsf_pt_i));

  // R7
  field_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (field_i != $past(field_i)) |-> $past(vsf_pt_i));

  // R11
  adj_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !commit_i |=> $stable(h_adj_i) && $stable(v_adj_i) && $stable(mid_mode_i));
endmodule

bind sg_timing_gen sg_timing_gen_chk #(
  .H_TOTAL (H_TOTAL),
  .V_TOTAL (V_TOTAL)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .hcnt_i     (hcnt),
  .vcnt_i     (vcnt),
  .commit_i   (frame_end),
  .h_adj_i    (h_adj),
  .v_adj_i    (v_adj),
  .mid_mode_i (mid_mode),
  .eav_pt_i   (eav_pt),
  .vsf_pt_i   (vsf_pt),
  .de_i       (de_o),
  .v_bit_i    (v_bit_o),
  .field_i    (field_o),
  .vs_n_i     (vs_n_o),
  .eav_i      (eav_o)
);

// File: tb/sg_timing_gen_tb.sv
module sg_timing_gen_tb;
  localparam int H = 40;
  localparam int V = 21;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [4:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic hs_n, vs_n, de, field, v_bit, f_bit, sav, eav;

  int n_chk = 0;
  int n_bad = 0;
  int ecnt = 0;

  always #4 clk = ~clk;

  always @(posedge clk) if (rst_n) ecnt <= ecnt + 1;

  sg_timing_gen #(
    .ADDR_W(5), .H_TOTAL(H), .H_ACTIVE(24), .HS_BEG_NOM(28), .HS_WID_NOM(6),
    .V_TOTAL(V), .V_DELAY(4),
    .VB_BEG_O(0), .VB_END_O(3), .VB_BEG_E(10), .VB_END_E(13),
    .FTOG_O(0), .FTOG_E(10),
    .VS_BEG_O(1), .VS_END_O(2), .VS_BEG_E(11), .VS_END_E(12)
  ) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .hs_n_o(hs_n), .vs_n_o(vs_n), .de_o(de),
    .field_o(field), .v_bit_o(v_bit), .f_bit_o(f_bit), .sav_o(sav), .eav_o(eav)
  );

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  // stop at the negedge where the outputs show pixel (l,h)
  task automatic wait_pos(int l, int h);
    do @(negedge clk);
    while (!(ecnt >= 1 && ((ecnt - 1) % H) == h && (((ecnt - 1) / H) % V) == l));
  endtask

  task automatic wr(int a, int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 5'(a); wr_data = 8'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    check("R13 hs_n", hs_n, 1);   check("R13 vs_n", vs_n, 1);
    check("R13 de", de, 0);       check("R13 v_bit", v_bit, 1);
    check("R13 f_bit", f_bit, 0); check("R13 field", field, 0);
    check("R13 sav", sav, 0);     check("R13 eav", eav, 0);
    rst_n = 1'b1;
  endtask

  task automatic t_counters();
    int gap, cnt;
    do @(negedge clk); while (!sav);
    gap = 0;
    do begin @(negedge clk); gap++; end while (!sav);
    check("R1 line period", gap, H);
    wait_pos(V - 1, H - 1);
    cnt = 0;
    for (int i = 0; i < H * V; i++) begin @(negedge clk); if (sav) cnt++; end
    check("R1 lines per frame", cnt, V);
  endtask

  task automatic t_horiz();
    wait_pos(8, 24); check("R2 eav at 24", eav, 1);
    wait_pos(8, 27); check("R2 hs before", hs_n, 1);
    wait_pos(8, 28); check("R2 hs begin", hs_n, 0);
    wait_pos(8, 33); check("R2 hs last", hs_n, 0);
    wait_pos(8, 34); check("R2 hs end", hs_n, 1);
    wait_pos(8, 35); check("R2 sav early", sav, 0);
    wait_pos(8, 36); check("R2 sav at 36", sav, 1);
  endtask

  task automatic t_de();
    wait_pos(5, 5);  check("R3 de in vblank", de, 0);
    wait_pos(8, 0);  check("R3 de first", de, 1);
    wait_pos(8, 23); check("R3 de last", de, 1);
    wait_pos(8, 24); check("R3 de off", de, 0);
  endtask

  task automatic t_vert();
    wait_pos(4, 23);  check("R5 v before delayed line", v_bit, 0);
    wait_pos(4, 24);  check("R5 v rise odd line 4", v_bit, 1);
    wait_pos(7, 23);  check("R4 v still high", v_bit, 1);
    wait_pos(7, 24);  check("R4 v fall odd", v_bit, 0);
    wait_pos(14, 24); check("R4 v rise even", v_bit, 1);
    wait_pos(17, 24); check("R4 v fall even", v_bit, 0);
  endtask

  task automatic t_vsync();
    wait_pos(5, 27);  check("R6 vs before", vs_n, 1);
    wait_pos(5, 28);  check("R6 vs odd begin", vs_n, 0);
    wait_pos(6, 28);  check("R6 vs odd end", vs_n, 1);
    wait_pos(15, 28); check("R6 vs even begin", vs_n, 0);
  endtask

  task automatic t_field();
    wait_pos(14, 23); check("R7 f before", f_bit, 0);
    wait_pos(14, 24); check("R7 f even", f_bit, 1);
    wait_pos(14, 27); check("R7 field before", field, 0);
    wait_pos(14, 28); check("R7 field even", field, 1);
    wait_pos(4, 24);  check("R7 f odd", f_bit, 0);
    wait_pos(4, 28);  check("R7 field odd", field, 0);
  endtask

  task automatic t_hoffset();
    wr(4, 8'h0F);                         // HS begin upper half only
    wait_pos(V - 1, H - 1);
    wait_pos(8, 20); check("R10 half write no effect", hs_n, 1);
    wait_pos(2, 0);
    wr(5, 8'hF8);                         // completes -8
    wr(0, 8'h00); wr(1, 8'h0A);           // SAV +10
    wait_pos(8, 28); check("R11 old hs this frame", hs_n, 0);
    wait_pos(8, 20); check("R8 hs moved -8", hs_n, 0);
    wait_pos(8, 25); check("R8 hs last", hs_n, 0);
    wait_pos(8, 26); check("R8 hs end", hs_n, 1);
    wait_pos(8, 6);  check("R8 sav wrapped", sav, 1);
    wait_pos(8, 36); check("R8 sav old pos", sav, 0);
  endtask

  task automatic t_vsf_mode();
    wr(28, 1);
    wait_pos(V - 1, H - 1);
    wait_pos(5, 7);  check("R12 vs before mid", vs_n, 1);
    wait_pos(5, 8);  check("R12 vs at mid", vs_n, 0);
    wait_pos(14, 7); check("R12 field before mid", field, 0);
    wait_pos(14, 8); check("R12 field at mid", field, 1);
  endtask

  task automatic t_voffset();
    wr(24, 2);      // VS begin odd +2
    wr(16, 8'h3B);  // V begin odd -5, wraps to line 20
    wait_pos(V - 1, H - 1);
    wait_pos(5, 8);   check("R9 vs odd not yet", vs_n, 1);
    wait_pos(7, 8);   check("R9 vs odd moved", vs_n, 0);
    wait_pos(15, 8);  check("R9 vs even kept", vs_n, 0);
    wait_pos(16, 8);  check("R9 vs even end", vs_n, 1);
    wait_pos(19, 24); check("R9 v before wrap", v_bit, 0);
    wait_pos(20, 24); check("R9 v wrapped line", v_bit, 1);
    wait_pos(4, 23);  check("R9 v held", v_bit, 1);
    wait_pos(14, 24); check("R9 v even kept", v_bit, 1);
  endtask

  initial begin
    t_reset();
    t_counters();
    t_horiz();
    t_de();
    t_vert();
    t_vsync();
    t_field();
    t_hoffset();
    t_vsf_mode();
    t_voffset();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule